// File: doc/BRIEF.md
# Watchdog Timer with Switchable Shared Divider

This block supervises a running device. A base counter advances on a slow, free-running watchdog tick that keeps running while the main clock of the device is stopped for sleep. The tick arrives as a one-cycle enable on the system clock. If software does not issue a clear command often enough, the watchdog times out. When the device is awake, a time-out raises a reset request. When the device is asleep, a time-out raises a wake-up pulse instead, and execution goes on.

A single binary divider with eight taps serves one of two users at a time. A route bit in an 8-bit option word picks the user. With the route bit at 1, the divider follows the base counter and stretches the time-out by 1, 2, 4 and so on up to 128. With the route bit at 0, the divider sits in front of a separate general-purpose timer and divides that timer's source pulses, while the watchdog times out at its bare base period. A 3-bit ratio select in the option word picks the tap.

A configuration enable held low switches the watchdog off for good. A status flag reads 1 after reset or after a clear command, and falls to 0 on any time-out.

Top module: `wdt_shared_presc`

## Requirements
- R1: After reset, `to_flag` is 1 and both `rst_req` and `wake_pulse` are 0.
- R2: With the route bit `opt[3]` at 0, a time-out occurs on the BASE_TICKS-th cycle in which `wdt_tick` is high, counted since the last restart. The matching event output is high for exactly the one cycle after that tick. Cycles with `wdt_tick` low do not advance the count.
- R3: With `opt[3]` at 1, the time-out period is BASE_TICKS × 2^`opt[2:0]` watchdog ticks, so the ratio runs from 1:1 to 1:128.
- R4: While `cfg_en` is 0, the base counter is held at zero and no time-out ever occurs. Counting restarts from zero once `cfg_en` returns to 1.
- R5: `clr_cmd` clears the base counter, and also clears the divider when `opt[3]` is 1. It sets `to_flag` to 1 one cycle later.
- R6: `sleep_cmd` restarts the base counter and the watchdog-routed divider in the same way as `clr_cmd`, but it leaves `to_flag` unchanged.
- R7: A time-out with `asleep` at 1 gives a one-cycle `wake_pulse` and no `rst_req`. With `asleep` at 0 it gives `rst_req` and no `wake_pulse`. The two outputs are never high together.
- R8: A time-out drives `to_flag` to 0 in the same cycle that the event output rises. The flag then stays at 0 until `clr_cmd`.
- R9: With `opt[3]` at 0, `tmr_tick` is high, in the same cycle, on every 2^`opt[2:0]`-th `tmr_src` pulse. With `opt[3]` at 1, `tmr_tick` equals `tmr_src`.
- R10: Any change of `opt[3]` clears the divider, so the next watchdog-routed time-out needs a full divided period.
- R11: A `clr_cmd` or `sleep_cmd` in the same cycle as the final tick suppresses the time-out. That tick does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_tick | input | 1 | One-cycle enable from the free-running watchdog oscillator |
| tmr_src | input | 1 | One-cycle source pulse for the general timer |
| clr_cmd | input | 1 | Clear command from software |
| sleep_cmd | input | 1 | Enter-sleep command |
| asleep | input | 1 | High while the device is in sleep mode |
| cfg_en | input | 1 | Configuration enable; 0 disables the watchdog |
| opt | input | 8 | Option word: bit 3 is the route bit, bits 2:0 the ratio select |
| rst_req | output | 1 | One-cycle device reset request |
| wake_pulse | output | 1 | One-cycle wake-up request |
| to_flag | output | 1 | Time-out status, 0 after a time-out |
| tmr_tick | output | 1 | Divided or passed-through pulse to the general timer |

## Verification
On every cycle, the checker confirms that reset requests and wake-ups exclude each other. It also confirms that each event follows the `asleep` level, that a disabled watchdog and a restart command silence the outputs, and that the flag tracks time-outs and clears. Only the bench scenarios can show that the time-out arrives after exactly the right number of ticks for each ratio and route. The same holds for the divider restarting when the route changes, `sleep_cmd` sparing the flag, and the timer output landing on the right source pulses. A reference model in the bench follows these through directed cases and a long random run.

// File: rtl/wdt_presc_pkg.sv
package wdt_presc_pkg;

   // where the shared divider is routed
   typedef enum logic {
      DIV_TO_TIMER = 1'b0,
      DIV_TO_WDOG  = 1'b1
   } div_route_e;

endpackage

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
   parameter int BASE_TICKS = 18,
   localparam int CNT_W     = $clog2(BASE_TICKS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic tick,
   output logic ovf
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   assign ovf = run & tick & ~restart & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || restart)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdt_shared_div.sv
module wdt_shared_div #(
   parameter int SEL_W  = 3,
   localparam int NTAPS = 1 << SEL_W,
   localparam int DIV_W = NTAPS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [SEL_W-1:0] sel,
   output logic             tap_hit
);
   logic [DIV_W-1:0] div_q;
   logic [NTAPS-1:0] hit;

   // tap k fires when the low k bits are all ones: one step in 2^k
   assign hit[0] = 1'b1;
   for (genvar k = 1; k < NTAPS; k++) begin : g_tap
      assign hit[k] = &div_q[k-1:0];
   end

   assign tap_hit = hit[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (clear)
         div_q <= '0;
      else if (step)
         div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
   input  logic clk,
   input  logic rst_n,
   input  logic timeout,
   input  logic asleep,
   input  logic clr_cmd,
   output logic rst_req,
   output logic wake_pulse,
   output logic to_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req    <= 1'b0;
         wake_pulse <= 1'b0;
         to_flag    <= 1'b1;
      end else begin
         rst_req    <= timeout & ~asleep;
         wake_pulse <= timeout & asleep;
         if (clr_cmd)
            to_flag <= 1'b1;
         else if (timeout)
            to_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/wdt_shared_presc.sv
module wdt_shared_presc
   import wdt_presc_pkg::*;
#(
   parameter int BASE_TICKS = 18,
   parameter int SEL_W      = 3,
   parameter int OPT_W      = 8,
   parameter int ROUTE_BIT  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wdt_tick,
   input  logic             tmr_src,
   input  logic             clr_cmd,
   input  logic             sleep_cmd,
   input  logic             asleep,
   input  logic             cfg_en,
   input  logic [OPT_W-1:0] opt,
   output logic             rst_req,
   output logic             wake_pulse,
   output logic             to_flag,
   output logic             tmr_tick
);
   if (BASE_TICKS < 2) begin : g_bad_base
      $error("BASE_TICKS must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must lie in 1..4");
   end
   if (ROUTE_BIT < SEL_W || ROUTE_BIT >= OPT_W) begin : g_bad_route
      $error("ROUTE_BIT must sit above the ratio field inside opt");
   end

   div_route_e       route, route_q;
   logic [SEL_W-1:0] sel;
   logic             restart, base_ovf, tap_hit, div_clear, div_step, timeout;
   logic             opt_unused_bits;

   assign route           = div_route_e'(opt[ROUTE_BIT]);
   assign sel             = opt[SEL_W-1:0];
   assign opt_unused_bits = ^opt;
   assign restart         = clr_cmd | sleep_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q <= DIV_TO_WDOG;
      else        route_q <= route;
   end

   wdt_base_cnt #(.BASE_TICKS(BASE_TICKS)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (cfg_en),
      .restart(restart),
      .tick   (wdt_tick),
      .ovf    (base_ovf)
   );

   assign div_clear = (route != route_q) | ((route == DIV_TO_WDOG) & restart);
   assign div_step  = (route == DIV_TO_WDOG) ? base_ovf : tmr_src;

   wdt_shared_div #(.SEL_W(SEL_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (div_clear),
      .step   (div_step),
      .sel    (sel),
      .tap_hit(tap_hit)
   );

   assign timeout  = base_ovf & ((route == DIV_TO_WDOG) ? tap_hit : 1'b1);
   assign tmr_tick = (route == DIV_TO_WDOG) ? tmr_src : (tmr_src & tap_hit);

   wdt_event u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .timeout   (timeout),
      .asleep    (asleep),
      .clr_cmd   (clr_cmd),
      .rst_req   (rst_req),
      .wake_pulse(wake_pulse),
      .to_flag   (to_flag)
   );
endmodule

// File: rtl/wdt_shared_presc_chk.sv
module wdt_shared_presc_chk (
   input logic clk,
   input logic rst_n,
   input logic clr_cmd,
   input logic sleep_cmd,
   input logic asleep,
   input logic cfg_en,
   input logic rst_req,
   input logic wake_pulse,
   input logic to_flag
);
   // R7
   excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && wake_pulse));

   // R7
   awake_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |=> !rst_req);

   // R7
   sleep_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !asleep |=> !wake_pulse);

   // R4
   cfg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !(rst_req || wake_pulse));

   // R8
   flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || wake_pulse) |-> !to_flag);

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |=> to_flag);

   // R11
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd || sleep_cmd) |=> !(rst_req || wake_pulse));

   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
endmodule

bind wdt_shared_presc wdt_shared_presc_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_cmd   (clr_cmd),
   .sleep_cmd (sleep_cmd),
   .asleep    (asleep),
   .cfg_en    (cfg_en),
   .rst_req   (rst_req),
   .wake_pulse(wake_pulse),
   .to_flag   (to_flag)
);

// File: tb/test_wdt_shared_presc.sv
module test_wdt_shared_presc;
   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wdt_tick = 0, tmr_src = 0, clr_cmd = 0, sleep_cmd = 0, asleep = 0, cfg_en = 1;
   logic [7:0] opt = 8'hFF;
   logic rst_req, wake_pulse, to_flag, tmr_tick;

   int n_chk = 0, n_fail = 0;
   int n_rst = 0, n_wake = 0, n_tt = 0;
   bit done = 0;

   // reference model state
   int m_base = 0, m_div = 0;
   bit m_asg_q = 1, m_rst = 0, m_wake = 0, m_flag = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_shared_presc #(.BASE_TICKS(BASE)) i_wdt_shared_presc (
      .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .tmr_src(tmr_src),
      .clr_cmd(clr_cmd), .sleep_cmd(sleep_cmd), .asleep(asleep), .cfg_en(cfg_en),
      .opt(opt), .rst_req(rst_req), .wake_pulse(wake_pulse), .to_flag(to_flag),
      .tmr_tick(tmr_tick)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit tap_hit(input int div, input int sel);
      int ratio = 1 << sel;
      return (div % ratio) == ratio - 1;
   endfunction

   // one clock cycle: drive, check the same-cycle timer output, step model, check registers
   task automatic cyc(input bit t, input bit s, input bit c, input bit p, input string tag);
      bit asg, hit, ovf, to, exp_tt;
      @(negedge clk);
      wdt_tick = t; tmr_src = s; clr_cmd = c; sleep_cmd = p;
      #1;
      asg = opt[3];
      hit = tap_hit(m_div, int'(opt[2:0]));
      exp_tt = asg ? s : (s && hit);
      chk(tmr_tick == exp_tt, "R9", "tmr_tick", tmr_tick, exp_tt);
      n_tt += tmr_tick;
      ovf = cfg_en && t && (m_base == BASE - 1) && !c && !p;
      to = ovf && (asg ? hit : 1'b1);
      m_rst = to && !asleep;
      m_wake = to && asleep;
      if (c) m_flag = 1; else if (to) m_flag = 0;
      if (!cfg_en || c || p) m_base = 0;
      else if (t) m_base = (m_base == BASE - 1) ? 0 : m_base + 1;
      if (asg != m_asg_q) m_div = 0;
      else if (asg && (c || p)) m_div = 0;
      else if (asg ? ovf : s) m_div = (m_div + 1) % 128;
      m_asg_q = asg;
      @(posedge clk); #1;
      chk(rst_req == m_rst, tag, "rst_req", rst_req, m_rst);
      chk(wake_pulse == m_wake, tag, "wake_pulse", wake_pulse, m_wake);
      chk(to_flag == m_flag, tag, "to_flag", to_flag, m_flag);
      n_rst += rst_req;
      n_wake += wake_pulse;
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, tag);
   endtask

   task automatic clear_counts();
      n_rst = 0; n_wake = 0; n_tt = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      chk(0, "WATCHDOG", "run did not finish", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(to_flag == 1, "R1", "to_flag", to_flag, 1);
      chk(rst_req == 0, "R1", "rst_req", rst_req, 0);
      chk(wake_pulse == 0, "R1", "wake_pulse", wake_pulse, 0);
      rst_n = 1;

      // R2 base period, divider on the timer
      opt = 8'h00;
      cyc(0, 0, 1, 0, "R5");
      clear_counts();
      for (int i = 0; i < 4; i++) begin cyc(1, 0, 0, 0, "R2"); cyc(0, 0, 0, 0, "R2"); end
      chk(n_rst == 0, "R2", "early reset count", n_rst, 0);
      cyc(1, 0, 0, 0, "R2");
      chk(rst_req == 1, "R2", "rst_req after 5th tick", rst_req, 1);
      chk(to_flag == 0, "R8", "to_flag after time-out", to_flag, 0);
      cyc(0, 0, 0, 0, "R2");
      chk(rst_req == 0, "R2", "pulse length", rst_req, 0);
      repeat (3) cyc(0, 0, 0, 0, "R8");
      chk(to_flag == 0, "R8", "to_flag holds", to_flag, 0);
      cyc(0, 0, 1, 0, "R5");
      chk(to_flag == 1, "R5", "to_flag after clear", to_flag, 1);

      // R3 postscaler 1:4 -> 20 ticks
      opt = 8'h0A;
      cyc(0, 0, 1, 0, "R3");
      clear_counts();
      ticks(19, "R3");
      chk(n_rst == 0, "R3", "reset before 20 ticks", n_rst, 0);
      ticks(1, "R3");
      chk(rst_req == 1, "R3", "rst_req at 20th tick", rst_req, 1);

      // R10 route change clears the divider
      cyc(0, 0, 1, 0, "R10");
      ticks(10, "R10");
      opt = 8'h02; cyc(0, 0, 0, 0, "R10");
      opt = 8'h0A; cyc(0, 0, 0, 0, "R10");
      clear_counts();
      ticks(19, "R10");
      chk(n_rst == 0, "R10", "reset before full period", n_rst, 0);
      ticks(1, "R10");
      chk(rst_req == 1, "R10", "rst_req after full period", rst_req, 1);

      // R6 sleep command restarts but spares the flag
      opt = 8'h09;
      cyc(0, 0, 1, 0, "R6");
      ticks(7, "R6");
      cyc(0, 0, 0, 1, "R6");
      clear_counts();
      ticks(9, "R6");
      chk(n_rst == 0, "R6", "reset before restarted period", n_rst, 0);
      ticks(1, "R6");
      chk(rst_req == 1, "R6", "rst_req after restart", rst_req, 1);
      cyc(0, 0, 0, 1, "R6");
      chk(to_flag == 0, "R6", "flag kept by sleep_cmd", to_flag, 0);

      // R7 time-out while asleep wakes
      opt = 8'h00; asleep = 1;
      cyc(0, 0, 1, 0, "R7");
      ticks(5, "R7");
      chk(wake_pulse == 1, "R7", "wake_pulse", wake_pulse, 1);
      chk(rst_req == 0, "R7", "no reset asleep", rst_req, 0);
      asleep = 0;

      // R4 disabled watchdog
      cfg_en = 0;
      clear_counts();
      ticks(50, "R4");
      chk(n_rst + n_wake == 0, "R4", "events while disabled", n_rst + n_wake, 0);
      cfg_en = 1;
      ticks(4, "R4");
      chk(rst_req == 0, "R4", "restart from zero", rst_req, 0);
      ticks(1, "R4");
      chk(rst_req == 1, "R4", "time-out after enable", rst_req, 1);

      // R11 clear on the final tick wins
      cyc(0, 0, 1, 0, "R11");
      ticks(4, "R11");
      cyc(1, 0, 1, 0, "R11");
      chk(rst_req == 0, "R11", "suppressed time-out", rst_req, 0);
      ticks(4, "R11");
      chk(rst_req == 0, "R11", "tick with clear not counted", rst_req, 0);
      ticks(1, "R11");
      chk(rst_req == 1, "R11", "full period after clear", rst_req, 1);

      // R9 timer prescaling and pass-through
      opt = 8'h02; cyc(0, 0, 0, 0, "R9");
      clear_counts();
      for (int i = 0; i < 8; i++) cyc(0, 1, 0, 0, "R9");
      chk(n_tt == 2, "R9", "divided timer pulses", n_tt, 2);
      opt = 8'h0B; cyc(0, 0, 0, 0, "R9");
      clear_counts();
      for (int i = 0; i < 8; i++) cyc(0, 1, 0, 0, "R9");
      chk(n_tt == 8, "R9", "passed-through timer pulses", n_tt, 8);

      // random run against the model
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 99) == 0)
            opt = {4'hF, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 3))};
         if ($urandom_range(0, 199) == 0) asleep = ~asleep;
         cfg_en = ($urandom_range(0, 49) != 0);
         cyc(1'($urandom_range(0, 1)), ($urandom_range(0, 9) < 3),
             ($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 1),
             opt[3] ? "R3" : "R2");
      end

      finish_run();
   end
endmodule